// File: doc/BRIEF.md
# Flow Signature Hash Engine

This block turns a flow description into a 32-bit filter hash for a receive flow classifier. It takes two 32-bit words. The flow word is kept uncompressed and carries the VLAN, the flow type and the pool. The common word has the source and destination addresses and ports XOR-folded into it. The result holds a bucket hash, used to index the filter table, in its low half. It holds a signature hash, stored with the filter and compared on a lookup, in its high half.

Each input word arrives as four bytes in wire order and is converted to host order first. Two working words are then built from the common word: a high word, and a low word that is the high word with its halves exchanged. The flow word is mixed into both working words. Each bit of two fixed 32-bit keys picks one working word and adds it, shifted, into one of three accumulators: common, bucket or signature. The common accumulator is folded into both halves at the end, and each half is then masked.

The engine is a single registered stage with a valid/ready handshake. It accepts a new input on every cycle while the consumer is ready. It holds its result while the consumer is stalled.

Top module: `flow_sig_hash`

## Requirements
- R1: While `rst` is high, `out_valid` is 0 and `out_hash` is 0 from the next clock edge. `in_ready` is 1 once `out_valid` is 0.
- R2: When NET_ORDER is 1, each input word is taken with bits [7:0] as the most significant byte. The four bytes are reversed before hashing.
- R3: The high working word is the converted common word XOR the converted flow word XOR (flow word >> 16). The flow word is applied before any key bit is used.
- R4: The low working word is the converted common word with its 16-bit halves exchanged. Key step 0 uses it unchanged. Steps 1 to 15 use it XOR the flow word XOR (flow word << 16).
- R5: For step n in 0..15, key bit n acts on the low working word and key bit n+16 acts on the high working word. A bit set in both keys XORs (word >> n) into the common accumulator. Otherwise, a bit set in the bucket key only XORs (word >> n) into the bucket accumulator. Otherwise, a bit set in the signature key only XORs (word << (16-n)) into the signature accumulator. All accumulators start at zero for every input.
- R6: `out_hash` is ((bucket ^ common) & MASK) ^ ((signature ^ (common << 16)) & (MASK << 16)), with the 15-bit MASK at 0x7FFF by default. No bit outside the two masked fields is ever 1.
- R7: An input accepted at a clock edge (`in_valid` and `in_ready` both 1) appears on `out_hash` with `out_valid` 1 right after that edge.
- R8: With `out_ready` held at 1, `in_ready` stays 1 and one input is accepted per cycle, with no bubbles.
- R9: While `out_valid` is 1 and `out_ready` is 0, `in_ready` is 0. `out_hash` and `out_valid` then hold unchanged, and a presented input is not taken.
- R10: If no input is accepted while the output is consumed or empty, `out_valid` is 0 after that edge.
- R11: Both input words at zero give a hash of zero.

## Ports
| Port | Direction | Width | Description |
|------|-----------|-------|-------------|
| clk | input | 1 | Clock |
| rst | input | 1 | Synchronous reset, active high |
| in_valid | input | 1 | Input words are present |
| in_ready | output | 1 | Engine can take an input this cycle |
| in_flow | input | 32 | Uncompressed flow word (VLAN, flow type, pool), wire byte order |
| in_common | input | 32 | XOR-folded address and port word, wire byte order |
| out_valid | output | 1 | `out_hash` holds a result |
| out_ready | input | 1 | Consumer takes the result this cycle |
| out_hash | output | 32 | Signature hash in [31:16], bucket hash in [15:0] |

## Verification
The bench targets the points where a hash engine goes quietly wrong.

- **Flow word applied to the low word too early.** If the flow word reaches the low working word before step 0, key bit 0 adds a flow-dependent term. Inputs carrying only a flow word then hash to the wrong bucket.
- **Reversed priority between the key sets.** Bits that both keys share would land in the bucket or signature accumulator. They would then be missing from the other half of the result.
- **Wrong byte order.** The hash would come out as a stable but wrong value, so directed single-byte inputs are compared against the reference model.
- **Handshake faults.** The bench streams inputs back to back and stalls the consumer while a new input waits. A bad handshake would drop or repeat a result, or overwrite a held one.

// File: rtl/fsh_pkg.sv
package fsh_pkg;
  localparam int WORD_W = 32;
  localparam int HALF_W = WORD_W / 2;
  localparam int BYTES  = WORD_W / 8;
  localparam int MASK_W = 15;

  typedef logic [WORD_W-1:0] word_t;

  function automatic word_t swap_halves(input word_t w);
    return {w[HALF_W-1:0], w[WORD_W-1:HALF_W]};
  endfunction
endpackage

// File: rtl/fsh_swap.sv
module fsh_swap
  import fsh_pkg::*;
#(
  parameter bit NET_ORDER = 1'b1
) (
  input  word_t wire_word,
  output word_t host_word
);
  generate
    if (NET_ORDER) begin : g_reverse
      for (genvar b = 0; b < BYTES; b++) begin : g_byte
        assign host_word[8*b +: 8] = wire_word[8*(BYTES-1-b) +: 8];
      end
    end else begin : g_pass
      assign host_word = wire_word;
    end
  endgenerate
endmodule

// File: rtl/fsh_lane.sv
module fsh_lane
  import fsh_pkg::*;
#(
  parameter int    STEP    = 0,
  parameter word_t BKT_KEY = 32'h5A3C_96E1,
  parameter word_t SIG_KEY = 32'h3C71_A58D
) (
  input  word_t lo_word,
  input  word_t hi_word,
  output word_t com_part,
  output word_t bkt_part,
  output word_t sig_part
);
  localparam int  SH_R  = STEP;
  localparam int  SH_L  = HALF_W - STEP;
  localparam int  HI_IX = STEP + HALF_W;
  localparam bit  LO_BK = BKT_KEY[STEP];
  localparam bit  LO_SK = SIG_KEY[STEP];
  localparam bit  HI_BK = BKT_KEY[HI_IX];
  localparam bit  HI_SK = SIG_KEY[HI_IX];
  localparam bit  LO_COM = LO_BK & LO_SK;
  localparam bit  LO_BKT = LO_BK & !LO_SK;
  localparam bit  LO_SIG = LO_SK & !LO_BK;
  localparam bit  HI_COM = HI_BK & HI_SK;
  localparam bit  HI_BKT = HI_BK & !HI_SK;
  localparam bit  HI_SIG = HI_SK & !HI_BK;

  word_t lo_r, hi_r, lo_l, hi_l;
  assign lo_r = lo_word >> SH_R;
  assign hi_r = hi_word >> SH_R;
  assign lo_l = lo_word << SH_L;
  assign hi_l = hi_word << SH_L;

  assign com_part = (LO_COM ? lo_r : '0) ^ (HI_COM ? hi_r : '0);
  assign bkt_part = (LO_BKT ? lo_r : '0) ^ (HI_BKT ? hi_r : '0);
  assign sig_part = (LO_SIG ? lo_l : '0) ^ (HI_SIG ? hi_l : '0);
endmodule

// File: rtl/fsh_fold.sv
module fsh_fold
  import fsh_pkg::*;
#(
  parameter logic [MASK_W-1:0] HASH_MASK = 15'h7FFF
) (
  input  word_t com_acc,
  input  word_t bkt_acc,
  input  word_t sig_acc,
  output word_t hash
);
  localparam word_t LO_KEEP = word_t'(HASH_MASK);
  localparam word_t HI_KEEP = LO_KEEP << HALF_W;

  word_t bkt_res, sig_res;
  assign bkt_res = (bkt_acc ^ com_acc) & LO_KEEP;
  assign sig_res = (sig_acc ^ (com_acc << HALF_W)) & HI_KEEP;
  assign hash    = bkt_res ^ sig_res;
endmodule

// File: rtl/flow_sig_hash.sv
module flow_sig_hash
  import fsh_pkg::*;
#(
  parameter word_t             BKT_KEY   = 32'h5A3C_96E1,
  parameter word_t             SIG_KEY   = 32'h3C71_A58D,
  parameter logic [MASK_W-1:0] HASH_MASK = 15'h7FFF,
  parameter bit                NET_ORDER = 1'b1
) (
  input  logic        clk,
  input  logic        rst,
  input  logic        in_valid,
  output logic        in_ready,
  input  logic [31:0] in_flow,
  input  logic [31:0] in_common,
  output logic        out_valid,
  input  logic        out_ready,
  output logic [31:0] out_hash
);
  localparam int    STEPS    = HALF_W;
  localparam word_t KEEP_ALL = (word_t'(HASH_MASK) << HALF_W) | word_t'(HASH_MASK);

  word_t flow_h, comm_h;
  fsh_swap #(.NET_ORDER(NET_ORDER)) u_swap_flow (.wire_word(in_flow),   .host_word(flow_h));
  fsh_swap #(.NET_ORDER(NET_ORDER)) u_swap_comm (.wire_word(in_common), .host_word(comm_h));

  // Working words: the high word takes the flow word up front (R3); the low
  // word only takes it after step 0 (R4).
  word_t hi_w, lo_pre, lo_post;
  assign hi_w    = comm_h ^ flow_h ^ (flow_h >> HALF_W);
  assign lo_pre  = swap_halves(comm_h);
  assign lo_post = lo_pre ^ flow_h ^ (flow_h << HALF_W);

  word_t com_ch [STEPS+1];
  word_t bkt_ch [STEPS+1];
  word_t sig_ch [STEPS+1];
  assign com_ch[0] = '0;
  assign bkt_ch[0] = '0;
  assign sig_ch[0] = '0;

  generate
    for (genvar n = 0; n < STEPS; n++) begin : g_step
      word_t c_p, b_p, s_p;
      fsh_lane #(.STEP(n), .BKT_KEY(BKT_KEY), .SIG_KEY(SIG_KEY)) u_lane (
        .lo_word (n == 0 ? lo_pre : lo_post),
        .hi_word (hi_w),
        .com_part(c_p),
        .bkt_part(b_p),
        .sig_part(s_p)
      );
      assign com_ch[n+1] = com_ch[n] ^ c_p;
      assign bkt_ch[n+1] = bkt_ch[n] ^ b_p;
      assign sig_ch[n+1] = sig_ch[n] ^ s_p;
    end
  endgenerate

  word_t hash_next;
  fsh_fold #(.HASH_MASK(HASH_MASK)) u_fold (
    .com_acc(com_ch[STEPS]),
    .bkt_acc(bkt_ch[STEPS]),
    .sig_acc(sig_ch[STEPS]),
    .hash   (hash_next)
  );

  assign in_ready = !out_valid || out_ready;

  always_ff @(posedge clk) begin
    if (rst) begin
      out_valid <= 1'b0;
      out_hash  <= '0;
    end else if (in_ready) begin
      out_valid <= in_valid;
      if (in_valid) out_hash <= hash_next;
    end
  end

  assert_reset_clear_R1: assert property (@(posedge clk)
    rst |=> (!out_valid && out_hash == '0));

  assert_field_mask_R6: assert property (@(posedge clk) disable iff (rst)
    (out_hash & ~KEEP_ALL) == '0);

  assert_one_cycle_R7: assert property (@(posedge clk) disable iff (rst)
    (in_valid && in_ready) |=> out_valid);

  assert_hold_on_stall_R9: assert property (@(posedge clk) disable iff (rst)
    (out_valid && !out_ready) |=> (out_valid && $stable(out_hash)));

  assert_drain_R10: assert property (@(posedge clk) disable iff (rst)
    (!in_valid && in_ready) |=> !out_valid);
endmodule

// File: tb/test_flow_sig_hash.sv
`timescale 1ns/1ps
module test_flow_sig_hash;
  typedef logic [31:0] w32;

  localparam w32          A_BK = 32'h5A3C_96E1;
  localparam w32          A_SK = 32'h3C71_A58D;
  localparam logic [14:0] A_MK = 15'h7FFF;
  localparam w32          B_BK = 32'hA1B2_0F3C;
  localparam w32          B_SK = 32'h0E5D_77C3;
  localparam logic [14:0] B_MK = 15'h1FFF;

  logic clk = 1'b0;
  logic rst = 1'b1;
  logic in_valid = 1'b0;
  logic out_ready = 1'b1;
  w32 in_flow = '0, in_common = '0;
  logic rdy_a, rdy_b, ov_a, ov_b;
  w32 h_a, h_b;

  always #5 clk = ~clk;

  flow_sig_hash i_flow_sig_hash (
    .clk(clk), .rst(rst), .in_valid(in_valid), .in_ready(rdy_a),
    .in_flow(in_flow), .in_common(in_common), .out_valid(ov_a),
    .out_ready(out_ready), .out_hash(h_a));

  flow_sig_hash #(.BKT_KEY(B_BK), .SIG_KEY(B_SK), .HASH_MASK(B_MK)) i_flow_sig_hash_alt (
    .clk(clk), .rst(rst), .in_valid(in_valid), .in_ready(rdy_b),
    .in_flow(in_flow), .in_common(in_common), .out_valid(ov_b),
    .out_ready(out_ready), .out_hash(h_b));

  int checks = 0;
  int fails = 0;

  function automatic w32 bswap(input w32 w);
    return {w[7:0], w[15:8], w[23:16], w[31:24]};
  endfunction

  // Loop-form reference of the hash, written from the requirements.
  function automatic w32 ref_hash(input w32 f_raw, input w32 c_raw,
                                  input w32 bk, input w32 sk, input logic [14:0] mk);
    w32 f, hi, lo, ca, ba, sa, w, m;
    f  = bswap(f_raw);
    hi = bswap(c_raw);
    lo = {hi[15:0], hi[31:16]};
    hi = hi ^ f ^ (f >> 16);
    ca = '0; ba = '0; sa = '0;
    for (int n = 0; n < 16; n++) begin
      if (n == 1) lo = lo ^ f ^ (f << 16);
      for (int half = 0; half < 2; half++) begin
        int p;
        p = n + 16 * half;
        w = half ? hi : lo;
        if (bk[p] && sk[p])  ca = ca ^ (w >> n);
        else if (bk[p])      ba = ba ^ (w >> n);
        else if (sk[p])      sa = sa ^ (w << (16 - n));
      end
    end
    m = {17'b0, mk};
    return ((ba ^ ca) & m) ^ ((sa ^ (ca << 16)) & (m << 16));
  endfunction

  task automatic chk(input bit ok, input string req, input w32 act, input w32 exp);
    checks++;
    if (!ok) begin
      fails++;
      $display("FAIL %s actual=%h expected=%h", req, act, exp);
    end
  endtask

  w32 exp_a, exp_b;
  bit pend = 0;
  string pend_req = "R5";

  // Check the result of the previous input, then drive the next one.
  task automatic step(input bit v, input w32 f, input w32 c, input string req);
    @(negedge clk);
    if (pend) begin
      chk(ov_a === 1'b1 && h_a === exp_a, pend_req, h_a, exp_a);
      chk(ov_b === 1'b1 && h_b === exp_b, {pend_req, " alt keys"}, h_b, exp_b);
    end else begin
      chk(ov_a === 1'b0 && ov_b === 1'b0, "R10 empty after idle", w32'(ov_a), 32'd0);
    end
    chk(rdy_a === 1'b1 && rdy_b === 1'b1, "R8 ready while consumer ready", w32'(rdy_a), 32'd1);
    in_valid  = v;
    in_flow   = f;
    in_common = c;
    pend      = v;
    pend_req  = req;
    exp_a     = ref_hash(f, c, A_BK, A_SK, A_MK);
    exp_b     = ref_hash(f, c, B_BK, B_SK, B_MK);
  endtask

  initial begin
    repeat (100000) @(posedge clk);
    fails++;
    $display("FAIL R8 watchdog actual=hung expected=finished");
    $display("End of test - %0d assertions evaluated, %0d failures", checks, fails);
    $finish;
  end

  initial begin
    w32 ea, eb;
    void'($urandom(32'd1357));
    repeat (3) @(negedge clk);
    chk(ov_a === 1'b0 && h_a === 32'd0, "R1 reset state", h_a, 32'd0);
    chk(ov_b === 1'b0 && h_b === 32'd0, "R1 reset state alt", h_b, 32'd0);
    rst = 1'b0;
    @(negedge clk);
    chk(rdy_a === 1'b1, "R1 ready after reset", w32'(rdy_a), 32'd1);

    // Directed corner cases.
    step(1, 32'h0, 32'h0, "R11 zero inputs");
    step(1, 32'h0000_00FF, 32'h0, "R2 R3 R4 flow only, top wire byte");
    step(1, 32'hFF00_0000, 32'h0, "R2 R4 flow only, last wire byte");
    step(1, 32'h0, 32'h0000_0001, "R2 common single bit, first byte");
    step(1, 32'h0, 32'h8000_0000, "R2 common single bit, last byte");
    step(1, 32'hFFFF_FFFF, 32'hFFFF_FFFF, "R5 R6 all ones");
    step(1, 32'h1234_5678, 32'h9ABC_DEF0, "R5 mixed pattern");
    step(0, 32'h0, 32'h0, "R10");
    @(negedge clk);
    chk(ref_hash(32'h0, 32'h0, A_BK, A_SK, A_MK) === 32'd0, "R11 model zero", 32'd0, 32'd0);

    // Random stream, mostly back to back.
    for (int i = 0; i < 400; i++) begin
      bit v;
      v = ($urandom % 5) != 0;
      step(v, $urandom, $urandom, "R5 R8 random stream");
    end
    step(0, 32'h0, 32'h0, "R10");

    // Stall: the result must hold and the waiting input must not be taken.
    @(negedge clk);
    out_ready = 1'b0;
    in_valid  = 1'b1;
    in_flow   = 32'hCAFE_0102;
    in_common = 32'h0BAD_F00D;
    ea = ref_hash(in_flow, in_common, A_BK, A_SK, A_MK);
    @(negedge clk);
    chk(ov_a === 1'b1 && h_a === ea, "R7 result one cycle after accept", h_a, ea);
    chk(rdy_a === 1'b0, "R9 not ready while stalled", w32'(rdy_a), 32'd0);
    in_flow   = 32'h7777_1111;
    in_common = 32'h2468_ACE0;
    eb = ref_hash(in_flow, in_common, A_BK, A_SK, A_MK);
    @(negedge clk);
    chk(ov_a === 1'b1 && h_a === ea, "R9 held during stall", h_a, ea);
    @(negedge clk);
    chk(ov_a === 1'b1 && h_a === ea, "R9 still held", h_a, ea);
    out_ready = 1'b1;
    @(negedge clk);
    chk(ov_a === 1'b1 && h_a === eb, "R9 waiting input taken after release", h_a, eb);
    in_valid = 1'b0;
    @(negedge clk);
    chk(ov_a === 1'b0, "R10 empty after drain", w32'(ov_a), 32'd0);

    // Reset mid-stream.
    in_valid  = 1'b1;
    in_flow   = 32'h1;
    in_common = 32'h2;
    @(negedge clk);
    rst = 1'b1;
    in_valid = 1'b0;
    @(negedge clk);
    chk(ov_a === 1'b0 && h_a === 32'd0, "R1 reset clears result", h_a, 32'd0);
    rst = 1'b0;

    $display("End of test - %0d assertions evaluated, %0d failures", checks, fails);
    $finish;
  end
endmodule